// File: doc/BRIEF.md
# Shared-Bus Hardwired Control Sequencer

This block is a small processor core in which every internal transfer travels over one shared data bus. A program counter, an instruction register, four general registers, a memory address register, a memory data register and the two ALU staging registers Y and Z each have a gate into the bus and a gate out of it. A step counter steps through a hardwired table. Each step opens a set of those gates, so one instruction runs as a short series of bus transfers. The only ALU operation is an add. Its first operand is either Y or the constant 4, and its second operand is whatever is on the bus. The sum goes into Z.

Memory sits behind the address and data registers and uses a request/completion handshake. A read or write request stays raised until the memory pulses `mem_done`. A step that must wait for memory freezes the step counter until that pulse arrives, so any memory latency is tolerated. The core runs four instruction kinds: add from memory, load, store and PC-relative branch. Each one starts with the same three-step fetch.

Instruction word (16 bits): bits [15:14] hold the opcode, bits [13:12] the address register A, bits [11:10] the data register D, and bits [7:0] a signed branch offset.

Top module: `sbus_ctrl_core`

## Requirements
- R1: While reset is held, `mem_rd` and `mem_wr` stay low. Reset clears the program counter and all four general registers to 0, so the first request after reset is a fetch read at address 0.
- R2: No step enables more than one source onto the shared bus.
- R3: Fetch reads the word at the current PC and latches it as the instruction. The PC then becomes PC+4 through the ALU's constant-4 input, so the fetch after a non-branch instruction is at the previous fetch address plus 4.
- R4: A read or write request stays asserted with a stable `mem_addr` until `mem_done`. During that time the step counter does not advance. On `mem_done` the read data enters the data register, and the request drops at the same edge.
- R5: Opcode 00 (add from memory) reads memory at address reg[A] and then sets reg[D] = reg[D] + that word, modulo 2^16.
- R6: Opcode 01 (load) reads memory at address reg[A] and then sets reg[D] = that word.
- R7: Opcode 10 (store) writes reg[D] to memory address reg[A], driving the value on `mem_wdata` with `mem_wr`.
- R8: Opcode 11 (branch) sets PC = (fetch address + 4) + sign-extended offset, modulo 2^16. This includes negative offsets that wrap below zero.
- R9: The last step of every instruction returns the step counter to fetch on the next clock. The next memory request after any instruction is therefore the fetch of the following instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_rd | output | 1 | Read request, held until completion |
| mem_wr | output | 1 | Write request, held until completion |
| mem_addr | output | 16 | Address from the memory address register |
| mem_wdata | output | 16 | Write data from the memory data register |
| mem_done | input | 1 | One-cycle completion pulse from memory |
| mem_rdata | input | 16 | Read data, valid in the cycle `mem_done` is high |

## Verification
The assertions assume that memory raises `mem_done` only while a request is outstanding, and only as a one-cycle pulse. They also assume that read data is valid in that same cycle. The bench's memory model answers only a request it is currently serving. It drives the completion pulse for exactly one cycle after a random wait of 0 to 3 cycles, or occasionally a long wait. It deasserts the pulse at the next falling edge, so the interface never leaves those assumptions.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int NGPR  = 4;
  localparam int OP_W  = 2;
  localparam int RSEL_W = 2;
  localparam int OFS_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_ADDM  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_JUMP  = 2'b11
  } op_e;

  typedef struct packed {
    logic [NGPR-1:0] gpr_out;
    logic [NGPR-1:0] gpr_in;
    logic pc_out;
    logic pc_in;
    logic ir_in;
    logic ofs_out;
    logic mar_in;
    logic mdr_in;
    logic mdr_out;
    logic y_in;
    logic z_in;
    logic z_out;
    logic use_four;
    logic rd_go;
    logic wr_go;
    logic wait_done;
    logic fin;
  } ctl_t;
endpackage

// File: rtl/sbus_seq.sv
module sbus_seq
  import sbus_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op,
  input  logic [RSEL_W-1:0] ra,
  input  logic [RSEL_W-1:0] rb,
  input  logic              mem_done,
  output ctl_t              ctl
);
  logic [STEP_W-1:0] step_q, step_d;
  logic              hold;

  function automatic logic [NGPR-1:0] pick(input logic [RSEL_W-1:0] idx);
    return NGPR'(1) << idx;
  endfunction

  always_comb begin
    ctl = '0;
    case (step_q)
      STEP_W'(0): begin
        ctl.pc_out = 1'b1; ctl.mar_in = 1'b1; ctl.rd_go = 1'b1;
        ctl.use_four = 1'b1; ctl.z_in = 1'b1;
      end
      STEP_W'(1): begin
        ctl.z_out = 1'b1; ctl.pc_in = 1'b1; ctl.y_in = 1'b1; ctl.wait_done = 1'b1;
      end
      STEP_W'(2): begin
        ctl.mdr_out = 1'b1; ctl.ir_in = 1'b1;
      end
      default: begin
        case (op_e'(op))
          OP_ADDM: case (step_q)
            STEP_W'(3): begin ctl.gpr_out = pick(ra); ctl.mar_in = 1'b1; ctl.rd_go = 1'b1; end
            STEP_W'(4): begin ctl.gpr_out = pick(rb); ctl.y_in = 1'b1; ctl.wait_done = 1'b1; end
            STEP_W'(5): begin ctl.mdr_out = 1'b1; ctl.z_in = 1'b1; end
            default:    begin ctl.z_out = 1'b1; ctl.gpr_in = pick(rb); ctl.fin = 1'b1; end
          endcase
          OP_LOAD: case (step_q)
            STEP_W'(3): begin ctl.gpr_out = pick(ra); ctl.mar_in = 1'b1; ctl.rd_go = 1'b1; end
            STEP_W'(4): ctl.wait_done = 1'b1;
            default:    begin ctl.mdr_out = 1'b1; ctl.gpr_in = pick(rb); ctl.fin = 1'b1; end
          endcase
          OP_STORE: case (step_q)
            STEP_W'(3): begin ctl.gpr_out = pick(ra); ctl.mar_in = 1'b1; end
            STEP_W'(4): begin ctl.gpr_out = pick(rb); ctl.mdr_in = 1'b1; ctl.wr_go = 1'b1; end
            default:    begin ctl.wait_done = 1'b1; ctl.fin = 1'b1; end
          endcase
          default: case (step_q)
            STEP_W'(3): begin ctl.ofs_out = 1'b1; ctl.z_in = 1'b1; end
            default:    begin ctl.z_out = 1'b1; ctl.pc_in = 1'b1; ctl.fin = 1'b1; end
          endcase
        endcase
      end
    endcase
  end

  assign hold = ctl.wait_done & ~mem_done;

  always_comb begin
    if (hold)         step_d = step_q;
    else if (ctl.fin) step_d = '0;
    else              step_d = step_q + STEP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assert_stall_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wait_done && !mem_done) |=> $stable(step_q));

  assert_end_goes_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.fin && !(ctl.wait_done && !mem_done)) |=> (step_q == '0));
endmodule

// File: rtl/sbus_memif.sv
module sbus_memif (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_go,
  input  logic wr_go,
  input  logic mem_done,
  output logic mem_rd,
  output logic mem_wr
);
  logic pend_q, pend_d, dir_q, dir_d;

  always_comb begin
    pend_d = pend_q;
    dir_d  = dir_q;
    if (mem_done) begin
      pend_d = 1'b0;
    end else if (rd_go || wr_go) begin
      pend_d = 1'b1;
      dir_d  = wr_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      dir_q  <= dir_d;
    end
  end

  assign mem_rd = pend_q & ~dir_q;
  assign mem_wr = pend_q & dir_q;

  assert_rd_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_done) |=> mem_rd);
  assert_wr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_done) |=> mem_wr);
  assert_done_drops_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_done |=> !(mem_rd || mem_wr));
  assert_done_only_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_done |-> (mem_rd || mem_wr));
endmodule

// File: rtl/sbus_dpath.sv
module sbus_dpath
  import sbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic          mem_done,
  input  logic          rd_pend,
  input  logic          req_busy,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] ir_q,
  output logic [DW-1:0] mar_q,
  output logic [DW-1:0] mdr_q
);
  logic [DW-1:0] pc_q, pc_d, y_q, z_q, bus, alu_a, alu_sum, ofs_ext;
  logic [DW-1:0] gpr_q [NGPR];
  logic [DW-1:0] gpr_d [NGPR];

  assign ofs_ext = {{(DW-OFS_W){ir_q[OFS_W-1]}}, ir_q[OFS_W-1:0]};

  always_comb begin
    bus = '0;
    if (ctl.pc_out)  bus = bus | pc_q;
    if (ctl.mdr_out) bus = bus | mdr_q;
    if (ctl.z_out)   bus = bus | z_q;
    if (ctl.ofs_out) bus = bus | ofs_ext;
    for (int i = 0; i < NGPR; i++)
      if (ctl.gpr_out[i]) bus = bus | gpr_q[i];
  end

  assign alu_a   = ctl.use_four ? DW'(4) : y_q;
  assign alu_sum = alu_a + bus;

  always_comb begin
    pc_d = ctl.pc_in ? bus : pc_q;
    for (int i = 0; i < NGPR; i++)
      gpr_d[i] = ctl.gpr_in[i] ? bus : gpr_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      for (int i = 0; i < NGPR; i++) gpr_q[i] <= '0;
    end else begin
      pc_q <= pc_d;
      for (int i = 0; i < NGPR; i++) gpr_q[i] <= gpr_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.ir_in)  ir_q  <= bus;
    if (ctl.mar_in) mar_q <= bus;
    if (ctl.y_in)   y_q   <= bus;
    if (ctl.z_in)   z_q   <= alu_sum;
    if (mem_done && rd_pend) mdr_q <= mem_rdata;
    else if (ctl.mdr_in)     mdr_q <= bus;
  end

  assert_one_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.gpr_out, ctl.pc_out, ctl.mdr_out, ctl.z_out, ctl.ofs_out}));
  assert_mdr_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done && rd_pend) |=> (mdr_q == $past(mem_rdata)));
  assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_busy && !mem_done) |=> $stable(mar_q));
endmodule

// File: rtl/sbus_ctrl_core.sv
module sbus_ctrl_core
  import sbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata
);
  localparam int OP_LSB = DW - OP_W;
  localparam int RA_LSB = OP_LSB - RSEL_W;
  localparam int RB_LSB = RA_LSB - RSEL_W;

  logic [1:0]    sync_q;
  logic          core_rst_n;
  ctl_t          ctl;
  logic [DW-1:0] ir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign core_rst_n = sync_q[1];

  sbus_seq #(.STEP_W(3)) u_seq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .op       (ir_q[OP_LSB +: OP_W]),
    .ra       (ir_q[RA_LSB +: RSEL_W]),
    .rb       (ir_q[RB_LSB +: RSEL_W]),
    .mem_done (mem_done),
    .ctl      (ctl)
  );

  sbus_memif u_memif (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .rd_go    (ctl.rd_go),
    .wr_go    (ctl.wr_go),
    .mem_done (mem_done),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr)
  );

  sbus_dpath #(.DW(DW)) u_dpath (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .ctl       (ctl),
    .mem_done  (mem_done),
    .rd_pend   (mem_rd),
    .req_busy  (mem_rd | mem_wr),
    .mem_rdata (mem_rdata),
    .ir_q      (ir_q),
    .mar_q     (mem_addr),
    .mdr_q     (mem_wdata)
  );
endmodule

// File: tb/sbus_ctrl_core_tb_top.sv
`timescale 1ns/1ps
module sbus_ctrl_core_tb_top;
  localparam int NINS  = 300;
  localparam int MAXT  = 1024;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, mem_done, mem_rd, mem_wr;
  logic [15:0] mem_rdata, mem_addr, mem_wdata;

  sbus_ctrl_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_done(mem_done), .mem_rdata(mem_rdata)
  );

  logic [15:0] mem_m [logic [15:0]];
  logic [15:0] mem_d [logic [15:0]];
  bit          exp_w [MAXT];
  logic [15:0] exp_a [MAXT];
  logic [15:0] exp_v [MAXT];
  string       exp_t [MAXT];
  int ntr = 0, checks = 0, fails = 0;

  function automatic logic [15:0] seed_word(logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] + {4'h3, a[3:0]}};
  endfunction

  function automatic logic [15:0] rd_m(logic [15:0] a);
    return mem_m.exists(a) ? mem_m[a] : seed_word(a);
  endfunction

  function automatic logic [15:0] rd_d(logic [15:0] a);
    return mem_d.exists(a) ? mem_d[a] : seed_word(a);
  endfunction

  function automatic void push(bit w, logic [15:0] a, logic [15:0] v, string t);
    if (ntr < MAXT) begin
      exp_w[ntr] = w; exp_a[ntr] = a; exp_v[ntr] = v; exp_t[ntr] = t;
      ntr++;
    end
  endfunction

  task automatic check(bit ok, string tag, string what, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic poke(logic [15:0] a, logic [15:0] v);
    mem_m[a] = v; mem_d[a] = v;
  endtask

  // Reference model from the requirements: predicts every memory transaction in order.
  task automatic build_model();
    logic [15:0] r [4];
    logic [15:0] pc, ir, a;
    string nxt;
    for (int i = 0; i < 4; i++) r[i] = '0;        // R1: registers cleared
    pc = '0; nxt = "R1";
    for (int n = 0; n < NINS; n++) begin
      push(1'b0, pc, '0, nxt);                    // fetch read at PC
      ir = rd_m(pc);
      pc = pc + 16'd4;                            // R3
      a = r[ir[13:12]];
      nxt = "R3";
      case (ir[15:14])
        2'b00: begin push(1'b0, a, '0, "R5"); r[ir[11:10]] = r[ir[11:10]] + rd_m(a); end
        2'b01: begin push(1'b0, a, '0, "R6"); r[ir[11:10]] = rd_m(a); end
        2'b10: begin push(1'b1, a, r[ir[11:10]], "R7"); mem_m[a] = r[ir[11:10]]; nxt = "R9"; end
        default: begin pc = pc + {{8{ir[7]}}, ir[7:0]}; nxt = "R8"; end
      endcase
    end
  endtask

  initial begin
    int idx, cyc, cnt, dly;
    bit busy;
    logic [15:0] held_a;
    bit held_w;
    rst_n = 1'b0; mem_done = 1'b0; mem_rdata = '0;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 64; k++) poke(16'(k * 4), 16'($urandom));
    // Directed start: load, forward branch, store, add, store, branch by -128
    poke(16'd0,  16'h4400);   // R1 = mem[R0]
    poke(16'd4,  16'hC008);   // PC = 8 + 8
    poke(16'd16, 16'h9400);   // mem[R1] = R1
    poke(16'd20, 16'h1400);   // R1 = R1 + mem[R1]
    poke(16'd24, 16'h8400);   // mem[R0] = R1
    poke(16'd28, 16'hC080);   // PC = 32 - 128, wraps
    build_model();

    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!(mem_rd || mem_wr), "R1", "request during reset", {15'd0, mem_rd | mem_wr}, 16'd0);
    end
    rst_n = 1'b1;

    idx = 0; cyc = 0; busy = 1'b0; cnt = 0; dly = 0; held_a = '0; held_w = 1'b0;
    while (idx < ntr && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      if (mem_done) begin
        mem_done = 1'b0; busy = 1'b0;
        check(!(mem_rd || mem_wr), "R4", "request after done", {15'd0, mem_rd | mem_wr}, 16'd0);
      end else if (busy) begin
        check((held_w ? mem_wr : mem_rd) && mem_addr == held_a, "R4", "held request/address",
              mem_addr, held_a);
        cnt++;
        if (cnt >= dly) begin
          mem_done = 1'b1;
          if (held_w) mem_d[mem_addr] = mem_wdata;
          else        mem_rdata = rd_d(mem_addr);
        end
      end else if (mem_rd || mem_wr) begin
        check(mem_wr == exp_w[idx], exp_t[idx], "kind", {15'd0, mem_wr}, {15'd0, exp_w[idx]});
        check(mem_addr == exp_a[idx], exp_t[idx], "address", mem_addr, exp_a[idx]);
        if (exp_w[idx]) // R2: a bus clash would corrupt this value
          check(mem_wdata == exp_v[idx], exp_t[idx], "write data (R2)", mem_wdata, exp_v[idx]);
        held_a = mem_addr; held_w = mem_wr;
        busy = 1'b1; cnt = 0;
        dly = (idx % 40 == 7) ? 14 : int'($urandom_range(0, 3));
        idx++;
        if (dly == 0) begin
          mem_done = 1'b1;
          if (held_w) mem_d[mem_addr] = mem_wdata;
          else        mem_rdata = rd_d(mem_addr);
        end
      end
    end
    if (idx < ntr) begin
      checks++; fails++;
      $display("FAIL watchdog R9 transactions actual=%0d expected=%0d", idx, ntr);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule